// File: doc/BRIEF.md
# Multi-Level Interrupt Status Controller

This block gathers level-sensitive interrupt requests from peripheral devices into four priority levels, numbered 3 through 6, with up to four devices on each level. Every level owns a status register, which shows the raw requests, and an enable register, which selects the devices allowed to raise that level's interrupt line. A simple single-cycle register bus reads both masks and writes the enables.

Each enable write carries a selector in data bit 7 that decides whether the devices flagged in data bits 3:0 are switched on or switched off. Devices that are not flagged keep their enable bit, so software never needs a read-modify-write. Each level drives one registered output line that is high while any enabled device on that level requests. Arbitration between the lines and vectoring are left to logic outside the block.

Top module: `irq_level_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every enable bit is 0, every level line is 0 and the read data is 0.
- R2: A read at byte offset 0x100 + 0x10 × L (L = 3..6) returns the live request inputs of level L in bits 3:0, bit i being device i, whatever the enable bits are.
- R3: A read at byte offset 0x104 + 0x10 × L returns the enable mask of level L in bits 3:0. Bits 7:4 of every read are 0.
- R4: A write to an enable offset with data bit 7 = 1 sets each enable bit whose device bit is 1 in data bits 3:0. The other enable bits keep their value (0x81 enables device 0, and 0x86 then adds devices 1 and 2).
- R5: A write to an enable offset with data bit 7 = 0 clears each enable bit whose device bit is 1 in data bits 3:0. The other enable bits keep their value (0x02 disables device 1 only).
- R6: Data bits 6:4 of an enable write have no effect.
- R7: Level line k (bit 0 = level 3) is high exactly one clock after a cycle in which some device of that level is both requesting and enabled, and low one clock after a cycle in which no such device exists.
- R8: A write to a status offset changes no enable bit.
- R9: A read at an unmapped offset returns 0. A write to an unmapped offset changes no enable bit.
- R10: Read data is registered. It is updated on the clock edge that accepts a read and holds its value through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| dev_req_i | input | 16 | Device requests, bits 4k+3:4k belong to level 3+k |
| lvl_irq_o | output | 4 | Interrupt line per level, bit k = level 3+k |

## Verification
The hardest case is proving that the set and clear encoding leaves unflagged enable bits alone. This needs a level whose mask already mixes ones and zeros before a write arrives. The stimulus reaches that state with the example sequence set-0, set-1-and-2, clear-1. It then sends writes whose only nonzero bits are in 6:4 and checks each resulting mask through an enable read. A second hard case is the one-clock latency of the level line. The bench changes a request between edges, checks that the line has not yet moved, and checks it again after the next edge.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 8;
  localparam int SET_BIT    = 7;
  localparam int STAT_BASE  = 'h100;
  localparam int EN_BASE    = 'h104;
  localparam int LVL_STRIDE = 'h010;

  function automatic logic [ADDR_W-1:0] stat_addr(int lvl);
    return ADDR_W'(STAT_BASE + LVL_STRIDE * lvl);
  endfunction

  function automatic logic [ADDR_W-1:0] en_addr(int lvl);
    return ADDR_W'(EN_BASE + LVL_STRIDE * lvl);
  endfunction
endpackage

// File: rtl/irq_lvl_decode.sv
module irq_lvl_decode
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int BASE_LVL = 3
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_LVL-1:0] stat_hit_o,
  output logic [NUM_LVL-1:0] en_hit_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign stat_hit_o[g] = (addr_i == stat_addr(BASE_LVL + g));
    assign en_hit_o[g]   = (addr_i == en_addr(BASE_LVL + g));
  end
endmodule

// File: rtl/irq_lvl_bank.sv
module irq_lvl_bank #(
  parameter int DEV_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             set_i,
  input  logic [DEV_N-1:0] mask_i,
  input  logic [DEV_N-1:0] req_i,
  output logic [DEV_N-1:0] en_o,
  output logic             irq_o
);
  logic [DEV_N-1:0] en_q;
  logic             irq_q;

  // set/clear: only flagged bits move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_i) begin
      if (set_i) en_q <= en_q | mask_i;
      else       en_q <= en_q & ~mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(req_i & en_q);
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_lvl_rdmux.sv
module irq_lvl_rdmux
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int DEV_N   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic [NUM_LVL-1:0]       stat_hit_i,
  input  logic [NUM_LVL-1:0]       en_hit_i,
  input  logic [NUM_LVL*DEV_N-1:0] stat_i,
  input  logic [NUM_LVL*DEV_N-1:0] en_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (stat_hit_i[k]) rd_next = rd_next | DATA_W'(stat_i[k*DEV_N +: DEV_N]);
      if (en_hit_i[k])   rd_next = rd_next | DATA_W'(en_i[k*DEV_N +: DEV_N]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int BASE_LVL = 3,
  parameter int DEV_N    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_req_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  input  logic [NUM_LVL*DEV_N-1:0] dev_req_i,
  output logic [NUM_LVL-1:0]       lvl_irq_o
);
  logic [NUM_LVL-1:0]       stat_hit;
  logic [NUM_LVL-1:0]       en_hit;
  logic [NUM_LVL*DEV_N-1:0] en_all;
  logic                     rd_stb;
  logic                     wr_stb;
  logic                     unused_wbits;

  assign rd_stb       = bus_req_i & ~bus_we_i;
  assign wr_stb       = bus_req_i & bus_we_i;
  assign unused_wbits = ^bus_wdata_i[SET_BIT-1:DEV_N];

  irq_lvl_decode #(.NUM_LVL(NUM_LVL), .BASE_LVL(BASE_LVL)) i_decode (
    .addr_i     (bus_addr_i),
    .stat_hit_o (stat_hit),
    .en_hit_o   (en_hit)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
    irq_lvl_bank #(.DEV_N(DEV_N)) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_stb & en_hit[g]),
      .set_i  (bus_wdata_i[SET_BIT]),
      .mask_i (bus_wdata_i[DEV_N-1:0]),
      .req_i  (dev_req_i[g*DEV_N +: DEV_N]),
      .en_o   (en_all[g*DEV_N +: DEV_N]),
      .irq_o  (lvl_irq_o[g])
    );
  end

  irq_lvl_rdmux #(.NUM_LVL(NUM_LVL), .DEV_N(DEV_N)) i_rdmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_stb),
    .stat_hit_i (stat_hit),
    .en_hit_i   (en_hit),
    .stat_i     (dev_req_i),
    .en_i       (en_all),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/irq_lvl_chk.sv
module irq_lvl_chk
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int BASE_LVL = 3,
  parameter int DEV_N    = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bus_req_i,
  input logic                     bus_we_i,
  input logic [ADDR_W-1:0]        bus_addr_i,
  input logic [DATA_W-1:0]        bus_wdata_i,
  input logic [DATA_W-1:0]        bus_rdata_o,
  input logic [NUM_LVL*DEV_N-1:0] dev_req_i,
  input logic [NUM_LVL-1:0]       lvl_irq_o,
  input logic [NUM_LVL*DEV_N-1:0] en_all
);
  a_r3_rdata_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:DEV_N] == '0);

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o));

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    a_r4_set_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i && bus_addr_i == en_addr(BASE_LVL + g) && bus_wdata_i[SET_BIT])
      |=> en_all[g*DEV_N +: DEV_N] == $past(en_all[g*DEV_N +: DEV_N] | bus_wdata_i[DEV_N-1:0]));

    a_r5_clear_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i && bus_addr_i == en_addr(BASE_LVL + g) && !bus_wdata_i[SET_BIT])
      |=> en_all[g*DEV_N +: DEV_N] == $past(en_all[g*DEV_N +: DEV_N] & ~bus_wdata_i[DEV_N-1:0]));

    // R8 / R9: only a write to this level's enable offset may move its mask
    a_r9_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_req_i && bus_we_i && bus_addr_i == en_addr(BASE_LVL + g))
      |=> $stable(en_all[g*DEV_N +: DEV_N]));

    a_r7_line_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> lvl_irq_o[g] == $past(|(dev_req_i[g*DEV_N +: DEV_N] & en_all[g*DEV_N +: DEV_N])));

    a_r2_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && !bus_we_i && bus_addr_i == stat_addr(BASE_LVL + g))
      |=> bus_rdata_o == $past(DATA_W'(dev_req_i[g*DEV_N +: DEV_N])));
  end
endmodule

bind irq_level_ctrl irq_lvl_chk #(
  .NUM_LVL(NUM_LVL), .BASE_LVL(BASE_LVL), .DEV_N(DEV_N)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .dev_req_i   (dev_req_i),
  .lvl_irq_o   (lvl_irq_o),
  .en_all      (en_all)
);

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [15:0] dev_req_i = '0;
  logic [3:0]  lvl_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_level_ctrl i_irq_level_ctrl (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .dev_req_i, .lvl_irq_o
  );

  function automatic logic [11:0] st_a(int k); return 12'(12'h100 + 12'h10 * (k + 3)); endfunction
  function automatic logic [11:0] en_a(int k); return 12'(12'h104 + 12'h10 * (k + 3)); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    @(negedge clk_i);
    bus_req_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 lines", 32'(lvl_irq_o), 0);
    chk("R1 rdata", 32'(bus_rdata_o), 0);
    for (int k = 0; k < 4; k++) begin
      rd(en_a(k), d);
      chk("R1 enable", 32'(d), 0);
    end
  endtask

  task automatic t_status();
    logic [7:0] d;
    dev_req_i = 16'hC5A3;
    for (int k = 0; k < 4; k++) begin
      rd(st_a(k), d);
      chk("R2 status", 32'(d), 32'(dev_req_i[k*4 +: 4]));
    end
    chk("R7 no enable no line", 32'(lvl_irq_o), 0);
    dev_req_i = 16'h0000;
  endtask

  task automatic t_set_clear();
    logic [7:0] d;
    wr(en_a(0), 8'h81); rd(en_a(0), d); chk("R4 set dev0", 32'(d), 1);
    wr(en_a(0), 8'h86); rd(en_a(0), d); chk("R4 add dev1 dev2", 32'(d), 7);
    wr(en_a(0), 8'h02); rd(en_a(0), d); chk("R5 clear dev1", 32'(d), 5);
    wr(en_a(0), 8'h8A); rd(en_a(0), d); chk("R4 set keeps others", 32'(d), 32'hF);
    wr(en_a(0), 8'h09); rd(en_a(0), d); chk("R5 clear keeps others", 32'(d), 6);
    rd(en_a(1), d); chk("R3 other level untouched", 32'(d), 0);
  endtask

  task automatic t_ignored_bits();
    logic [7:0] d;
    wr(en_a(1), 8'h85);
    wr(en_a(1), 8'hF0); rd(en_a(1), d); chk("R6 set with 6:4 only", 32'(d), 5);
    wr(en_a(1), 8'h70); rd(en_a(1), d); chk("R6 clear with 6:4 only", 32'(d), 5);
    wr(en_a(1), 8'hF2); rd(en_a(1), d); chk("R6 set dev1 with 6:4", 32'(d), 7);
  endtask

  task automatic t_line();
    wr(en_a(2), 8'h84);
    @(negedge clk_i);
    dev_req_i = 16'h0B00;                 // level 5, devices 0,1,3 not enabled
    @(negedge clk_i);
    chk("R7 unenabled request", 32'(lvl_irq_o[2]), 0);
    dev_req_i = 16'h0400;
    chk("R7 before edge", 32'(lvl_irq_o[2]), 0);
    @(negedge clk_i);
    chk("R7 after edge", 32'(lvl_irq_o), 32'h4);
    dev_req_i = 16'h0000;
    @(negedge clk_i);
    chk("R7 drop", 32'(lvl_irq_o), 0);
    dev_req_i = 16'h0400;
    @(negedge clk_i);
    wr(en_a(2), 8'h04);                   // line falls one edge after enable clears
    chk("R7 after disable edge", 32'(lvl_irq_o[2]), 1);
    @(negedge clk_i);
    chk("R7 disabled line low", 32'(lvl_irq_o[2]), 0);
    dev_req_i = 16'h0000;
  endtask

  task automatic t_status_write();
    logic [7:0] d;
    wr(st_a(3), 8'h8F); rd(en_a(3), d); chk("R8 status write set", 32'(d), 0);
    wr(en_a(3), 8'h83);
    wr(st_a(3), 8'h0F); rd(en_a(3), d); chk("R8 status write clear", 32'(d), 3);
    dev_req_i = 16'h9000;
    rd(st_a(3), d); chk("R8 status still live", 32'(d), 9);
    dev_req_i = 16'h0000;
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    dev_req_i = 16'hFFFF;
    rd(12'h108, d); chk("R9 read 0x108", 32'(d), 0);
    rd(12'h120, d); chk("R9 read 0x120", 32'(d), 0);
    rd(12'h174, d); chk("R9 read 0x174", 32'(d), 0);
    wr(12'h124, 8'h8F); wr(12'h174, 8'h8F); wr(12'h135, 8'h8F); wr(12'h138, 8'h0F);
    rd(en_a(0), d); chk("R9 lvl3 unchanged", 32'(d), 6);
    rd(en_a(1), d); chk("R9 lvl4 unchanged", 32'(d), 7);
    rd(en_a(3), d); chk("R9 lvl6 unchanged", 32'(d), 3);
    dev_req_i = 16'h0000;
  endtask

  task automatic t_hold();
    logic [7:0] d;
    rd(en_a(1), d);
    chk("R10 read value", 32'(d), 7);
    repeat (3) @(negedge clk_i);
    chk("R10 hold idle", 32'(bus_rdata_o), 7);
    wr(en_a(2), 8'h8F);
    chk("R10 hold over write", 32'(bus_rdata_o), 7);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_status();
    t_set_clear();
    t_ignored_bits();
    t_line();
    t_status_write();
    t_unmapped();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule